// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a host port that writes one 32-bit dword per cycle and a bank of 128-bit control registers. A register in the bank can only be loaded whole. The block therefore gathers the dwords the host sends to one register and hands the complete 128-bit value to the bank as one update. Each register spans four consecutive dword addresses. The update is triggered when the host writes the uppermost dword. Any lower dword that was never supplied goes to the bank as zero.

The collector holds at most one register at a time. A two-state machine controls it:

- **ST_EMPTY** means nothing is held.
- **ST_HOLD** means one register index and some of its lower dwords are held.

The machine has these transitions:

- **capture** (ST_EMPTY to ST_HOLD): a lower-dword write arrives while the collector is empty.
- **gather** (ST_HOLD to ST_HOLD): a lower-dword write arrives for the held register.
- **drop** (ST_HOLD to ST_HOLD, nothing changes): a lower-dword write arrives for another register.
- **fire_held** (ST_HOLD to ST_EMPTY): the top dword of the held register is written.
- **fire_bypass**: the top dword of a register that is not held is written. This stays in ST_HOLD, or stays in ST_EMPTY if the collector was empty.

The commit to the bank is a registered output. The strobe, index and data all appear together on the clock edge that follows the top-dword write.

Top module: `wide_reg_collector`

## Requirements
- R1: `wr_addr` is a dword address. Bits [1:0] select the dword lane within a register (lane 3 holds bits 127:96, and lane 0 holds bits 31:0). Bits [IDX_W+1:2] form the register index.
- R2: A write with lane 3 makes `commit_vld` high for exactly the following cycle. `commit_idx` and `commit_data` are valid in that same cycle. No other write, and no idle cycle, raises `commit_vld`.
- R3: At commit, `commit_data[127:96]` equals the top-dword write data, and `commit_idx` equals the index of that write.
- R4: At commit of the held register, each lower lane carries its stored dword if that lane was written, and zero otherwise.
- R5: While empty, a write to lane 0, 1 or 2 captures that write's register index, stores the dword and marks the lane valid.
- R6: A further lower-lane write to the held register replaces that lane's stored dword.
- R7: While holding, a lower-lane write to a different register is discarded. The held index and the held dwords stay unchanged.
- R8: A top-dword write to a register other than the held one commits that register with bits 95:0 zero. The held register and its dwords are kept for a later commit.
- R9: After the held register commits, the collector is empty. A later commit of that register carries no earlier dwords. A lower-lane write to any register is captured again.
- R10: Three- or four-dword bursts into one register, on consecutive cycles and ending with lane 3, commit as one update with every supplied lane and zero in the missing ones.
- R11: A synchronous reset (`rst` high) empties the collector and clears all lane valid flags. `commit_vld` is low in the cycle after any reset cycle, even if a top-dword write was present during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | IDX_W+2 | Dword address: register index above, lane in [1:0] |
| wr_data | input | 32 | Host write data |
| commit_vld | output | 1 | One-cycle strobe loading a bank register |
| commit_idx | output | IDX_W | Index of the register being loaded |
| commit_data | output | 128 | Full value for that register |

## Verification
The bench aims at these corner cases, and at what a faulty design would show in each:

- **Top write with nothing held.** A faulty design would leak stale data into the lower 96 bits.
- **Stray lower-lane write from another register while holding.** A faulty design would overwrite the held lane or take over the held index, so the later commit would show the wrong data.
- **Top write to a foreign register.** A faulty design would either spill the held dwords into that commit or lose them before their own commit.
- **Reuse of a register after its commit.** A design that does not clear its valid flags would resend old dwords instead of zero.
- **Three- and four-dword bursts, and a reset that coincides with a top write.** These show whether the collector drops a lane when writes arrive on back-to-back cycles, and whether reset suppresses the strobe.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    localparam int DW       = 32;
    localparam int LANES    = 4;
    localparam int LANE_W   = $clog2(LANES);
    localparam int REG_W    = DW * LANES;
    localparam int LOW_W    = DW * (LANES - 1);
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } col_state_t;

    typedef struct packed {
        logic load;      // store the current dword into its lane
        logic take_idx;  // latch the current register index
        logic clear;     // drop all lane valid flags
        logic fire;      // launch a commit
        logic use_held;  // commit uses held lower lanes
    } col_ctl_t;
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W+LANE_W-1:0] addr,
    output logic [IDX_W-1:0]        idx,
    output logic [LANE_W-1:0]       lane,
    output logic                    is_top
);
    always_comb begin
        lane   = addr[LANE_W-1:0];
        idx    = addr[IDX_W+LANE_W-1:LANE_W];
        is_top = (addr[LANE_W-1:0] == TOP_LANE);
    end
endmodule

// File: rtl/wrc_lane_store.sv
module wrc_lane_store
    import wrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  logic [LANE_W-1:0] lane,
    input  logic [DW-1:0]     wdata,
    input  logic              use_held,
    output logic [LOW_W-1:0]  low_bits
);
    localparam int NLOW = LANES - 1;

    logic [NLOW-1:0][DW-1:0] lane_q;
    logic [NLOW-1:0]         lane_vld;

    for (genvar g = 0; g < NLOW; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_vld[g] <= 1'b0;
                lane_q[g]   <= '0;
            end else if (clear) begin
                lane_vld[g] <= 1'b0;
            end else if (load && lane == LANE_W'(g)) begin
                lane_vld[g] <= 1'b1;
                lane_q[g]   <= wdata;
            end
        end

        always_comb begin
            low_bits[g*DW +: DW] = (use_held && lane_vld[g]) ? lane_q[g] : '0;
        end
    end
endmodule

// File: rtl/wrc_ctrl.sv
module wrc_ctrl
    import wrc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             is_top,
    output col_ctl_t         ctl,
    output col_state_t       state,
    output logic [IDX_W-1:0] held_idx
);
    col_state_t state_nxt;
    logic       same_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_EMPTY;
            held_idx <= '0;
        end else begin
            state <= state_nxt;
            if (ctl.take_idx) begin
                held_idx <= idx;
            end
        end
    end

    always_comb begin
        same_reg  = (idx == held_idx);
        state_nxt = state;
        ctl       = '0;
        unique case (state)
            ST_EMPTY: begin
                if (wr_en && is_top) begin
                    ctl.fire = 1'b1;                // fire_bypass
                end else if (wr_en) begin
                    ctl.load     = 1'b1;            // capture
                    ctl.take_idx = 1'b1;
                    state_nxt    = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (wr_en && is_top && same_reg) begin
                    ctl.fire     = 1'b1;            // fire_held
                    ctl.use_held = 1'b1;
                    ctl.clear    = 1'b1;
                    state_nxt    = ST_EMPTY;
                end else if (wr_en && is_top) begin
                    ctl.fire = 1'b1;                // fire_bypass
                end else if (wr_en && same_reg) begin
                    ctl.load = 1'b1;                // gather
                end
                // other-register lower write: drop
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end
endmodule

// File: rtl/wrc_commit_reg.sv
module wrc_commit_reg
    import wrc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    top_dword,
    input  logic [LOW_W-1:0] low_bits,
    output logic             vld,
    output logic [IDX_W-1:0] out_idx,
    output logic [REG_W-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= 1'b0;
            out_idx  <= '0;
            out_data <= '0;
        end else begin
            vld <= fire;
            if (fire) begin
                out_idx  <= idx;
                out_data <= {top_dword, low_bits};
            end
        end
    end
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W+1:0]   wr_addr,
    input  logic [31:0]        wr_data,
    output logic               commit_vld,
    output logic [IDX_W-1:0]   commit_idx,
    output logic [127:0]       commit_data
);
    logic [IDX_W-1:0]  dec_idx;
    logic [LANE_W-1:0] dec_lane;
    logic              dec_top;
    col_ctl_t          ctl;
    col_state_t        fsm_state;
    logic [IDX_W-1:0]  held_idx;
    logic [LOW_W-1:0]  low_bits;

    wrc_decode #(.IDX_W(IDX_W)) u_decode (
        .addr   (wr_addr),
        .idx    (dec_idx),
        .lane   (dec_lane),
        .is_top (dec_top)
    );

    wrc_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .idx      (dec_idx),
        .is_top   (dec_top),
        .ctl      (ctl),
        .state    (fsm_state),
        .held_idx (held_idx)
    );

    wrc_lane_store u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .clear    (ctl.clear),
        .lane     (dec_lane),
        .wdata    (wr_data),
        .use_held (ctl.use_held),
        .low_bits (low_bits)
    );

    wrc_commit_reg #(.IDX_W(IDX_W)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .fire      (ctl.fire),
        .idx       (dec_idx),
        .top_dword (wr_data),
        .low_bits  (low_bits),
        .vld       (commit_vld),
        .out_idx   (commit_idx),
        .out_data  (commit_data)
    );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
    import wrc_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W+1:0] wr_addr,
    input logic [31:0]      wr_data,
    input logic             commit_vld,
    input logic [IDX_W-1:0] commit_idx,
    input logic [127:0]     commit_data,
    input col_state_t       fsm_state,
    input logic [IDX_W-1:0] held_idx
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    logic top_wr;
    logic [IDX_W-1:0] wr_idx;
    always_comb begin
        top_wr = wr_en && (wr_addr[1:0] == 2'd3);
        wr_idx = wr_addr[IDX_W+1:2];
    end

    // R2
    top_commit_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        top_wr |=> commit_vld);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !top_wr |=> !commit_vld);

    // R3
    top_data_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        top_wr |=> (commit_data[127:96] == $past(wr_data)) && (commit_idx == $past(wr_idx)));

    // R7
    discard_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (fsm_state == ST_HOLD && wr_en && !top_wr && wr_idx != held_idx)
        |=> (fsm_state == ST_HOLD) && (held_idx == $past(held_idx)));

    // R9
    empty_after_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (fsm_state == ST_HOLD && top_wr && wr_idx == held_idx) |=> (fsm_state == ST_EMPTY));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!commit_vld && fsm_state == ST_EMPTY));
endmodule

bind wide_reg_collector wrc_checker #(.IDX_W(IDX_W)) u_wrc_checker (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit_vld  (commit_vld),
    .commit_idx  (commit_idx),
    .commit_data (commit_data),
    .fsm_state   (fsm_state),
    .held_idx    (held_idx)
);

// File: tb/test_wide_reg_collector.sv
`timescale 1ns/1ps
module test_wide_reg_collector;
    localparam int IDX_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic [IDX_W+1:0]   wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               commit_vld;
    logic [IDX_W-1:0]   commit_idx;
    logic [127:0]       commit_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model of the collector
    bit              m_hold;
    logic [IDX_W-1:0] m_idx;
    logic [31:0]     m_dat [3];
    bit              m_vld [3];

    always #4 clk = ~clk;

    wide_reg_collector #(.IDX_W(IDX_W)) i_wide_reg_collector (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit_vld  (commit_vld),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    function automatic logic [IDX_W+1:0] mk_addr(input int ridx, input int lane);
        return {IDX_W'(ridx), 2'(lane)};
    endfunction

    function automatic logic [95:0] held_low();
        logic [95:0] r = '0;
        for (int i = 0; i < 3; i++) if (m_vld[i]) r[i*32 +: 32] = m_dat[i];
        return r;
    endfunction

    task automatic model_clear();
        m_hold = 1'b0;
        m_idx  = '0;
        for (int i = 0; i < 3; i++) begin m_vld[i] = 1'b0; m_dat[i] = '0; end
    endtask

    task automatic check(input string req, input bit ev, input logic [IDX_W-1:0] ei,
                         input logic [127:0] ed);
        n_cmp++;
        if (commit_vld !== ev || (ev && (commit_idx !== ei || commit_data !== ed))) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b idx=%0h data=%032h, expected vld=%0b idx=%0h data=%032h",
                     req, commit_vld, commit_idx, commit_data, ev, ei, ed);
        end
    endtask

    // one host cycle; the registered commit is sampled after the next edge
    task automatic step(input bit en, input int ridx, input int lane,
                        input logic [31:0] d, input string req);
        bit ev = 1'b0;
        logic [IDX_W-1:0] ei = '0;
        logic [127:0] ed = '0;
        logic [IDX_W-1:0] ri = IDX_W'(ridx);
        @(negedge clk);
        wr_en = en; wr_addr = mk_addr(ridx, lane); wr_data = d;
        if (en) begin
            if (lane == 3) begin
                ev = 1'b1; ei = ri;
                if (m_hold && ri == m_idx) begin
                    ed = {d, held_low()};
                    model_clear();
                end else begin
                    ed = {d, 96'b0};
                end
            end else if (!m_hold) begin
                m_hold = 1'b1; m_idx = ri; m_dat[lane] = d; m_vld[lane] = 1'b1;
            end else if (ri == m_idx) begin
                m_dat[lane] = d; m_vld[lane] = 1'b1;
            end
        end
        @(posedge clk); #2;
        check(req, ev, ei, ed);
    endtask

    task automatic do_reset(input bit with_top);
        @(negedge clk);
        rst = 1'b1;
        wr_en = with_top; wr_addr = mk_addr(9, 3); wr_data = 32'hDEAD_0001;
        @(posedge clk); #2;
        check("R11 reset", 1'b0, '0, '0);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        model_clear();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        // R11: reset state
        @(posedge clk); #2;
        check("R11 reset state", 1'b0, '0, '0);
        do_reset(1'b1);

        // R10 / R4: four-dword burst
        step(1, 5, 0, 32'h1111_0000, "R5 capture");
        step(1, 5, 1, 32'h1111_0001, "R10 burst");
        step(1, 5, 2, 32'h1111_0002, "R10 burst");
        step(1, 5, 3, 32'h1111_0003, "R10 R4 four-dword commit");
        // R10: three-dword burst, lane 0 missing -> zero
        step(1, 6, 1, 32'h2222_0001, "R5 capture");
        step(1, 6, 2, 32'h2222_0002, "R10 burst");
        step(1, 6, 3, 32'h2222_0003, "R10 R4 three-dword commit");
        // R2 R3: top only while empty
        step(1, 7, 3, 32'h3333_0003, "R3 top while empty");
        step(0, 7, 3, 32'h0, "R2 idle no strobe");
        // R7 R8: hold reg 2, stray writes to reg 7
        step(1, 2, 0, 32'h4444_0000, "R5 capture");
        step(1, 7, 1, 32'h5555_0001, "R7 stray discarded");
        step(1, 7, 0, 32'h5555_0000, "R7 stray discarded");
        step(1, 7, 3, 32'h5555_0003, "R8 foreign top zero low");
        step(1, 2, 0, 32'h4444_00AA, "R6 overwrite");
        step(1, 2, 3, 32'h4444_0003, "R8 R6 R7 held commit");
        // R9: reuse after commit
        step(1, 2, 3, 32'h4444_1003, "R9 no stale lanes");
        step(1, 9, 2, 32'h6666_0002, "R9 recapture");
        step(1, 9, 3, 32'h6666_0003, "R9 recapture commit");
        // R1: highest index
        step(1, 255, 1, 32'h7777_0001, "R1 index decode");
        step(1, 255, 3, 32'h7777_0003, "R1 index decode commit");
        // R11: reset while holding
        step(1, 4, 0, 32'h8888_0000, "R5 capture");
        do_reset(1'b0);
        step(1, 4, 3, 32'h8888_0003, "R11 reset emptied");

        // constrained random mix over a few registers
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 3));
            int l = int'($urandom_range(0, 3));
            bit e = ($urandom_range(0, 9) < 8);
            step(e, r, l, $urandom(), "R2 R4 R7 R8 random");
            if ($urandom_range(0, 499) == 0) do_reset($urandom_range(0, 1) == 1);
        end
        step(0, 0, 0, 32'h0, "R2 idle");
        finish_up();
    end
endmodule